// File: doc/BRIEF.md
# Dual-Mode 4:2:2 Pixel Input Demultiplexer

This block takes a 4:2:2 YCbCr pixel stream and gathers it into aligned pixel pairs. Each pair is one group of four components: a shared blue-difference chroma sample, the luma of the first pixel, a shared red-difference chroma sample and the luma of the second pixel. When a group is complete, the block presents it on four separate output buses together with a single-cycle valid strobe.

Two input formats are selectable. In byte-serial format, one 8-bit sample arrives on the low byte of the input bus at every rising clock edge, and the samples follow a repeating chroma-blue, luma, chroma-red, luma cycle. In split-bus format, luma arrives on the low byte and time-multiplexed chroma arrives on the high byte. The block captures only on every second rising edge, and the chroma alternates blue first, then red. A line-start strobe realigns the sample phase. Changing the format select drops any half-built group.

Top module: `ycc_pair_demux`

## Requirements
- R1: While reset is high and in the cycle after it is released, `valid_o` is 0 and all four component outputs are 0. The format in use after reset is byte-serial (`mode_sel` = 0).
- R2: In byte-serial format, a sample is taken from `din[7:0]` at every rising edge. The samples fill the group in the order blue chroma, first luma, red chroma, second luma.
- R3: In split-bus format (`mode_sel` = 1), each capture takes luma from `din[7:0]` and chroma from `din[15:8]`. The first capture of a group supplies blue chroma and first luma. The second capture supplies red chroma and second luma.
- R4: In split-bus format, a capture is followed by exactly one skipped edge, and the data on the skipped edge has no effect on any output.
- R5: `valid_o` is high for exactly one cycle, in the cycle after the edge that captures the last sample of a group, and the component outputs hold the group's values until the next group completes.
- R6: When `line_start` is high at an edge, the data on that edge is captured as the first sample of a new group (blue chroma in byte-serial format, or the blue-chroma/first-luma pair in split-bus format), and any partial group is discarded. In split-bus format this edge is always a capture edge.
- R7: An edge at which `mode_sel` differs from the format in use captures nothing and emits nothing, discards any partial group, and makes `mode_sel` the format in use from the next edge on.
- R8: In byte-serial format, `din[15:8]` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 = byte-serial format, 1 = split-bus format |
| line_start | input | 1 | Marks the first sample of a line and realigns the phase |
| din | input | 16 | Pixel input bus |
| cb_o | output | 8 | Blue chroma of the last completed group |
| y0_o | output | 8 | First-pixel luma of the last completed group |
| cr_o | output | 8 | Red chroma of the last completed group |
| y1_o | output | 8 | Second-pixel luma of the last completed group |
| valid_o | output | 1 | One-cycle strobe marking a new group |

## Verification
A table of six distinct component groups is sent in both formats. In byte-serial format, the upper byte carries a value that differs from every sample, so any leak of the high byte or any swap of slot order changes the result. In split-bus format, the skipped edges carry junk that no group contains, which shows whether the skip phase is honoured. Directed sequences then check the following: a line start that arrives mid-group, a format change that arrives mid-group and must leave no trace of the old samples, and the holding of outputs after a strobe.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

    parameter int SAMPLE_W = 8;
    localparam int BUS_W   = 2 * SAMPLE_W;
    localparam int SLOT_W  = 2;

    typedef enum logic {
        FMT_BYTE  = 1'b0,
        FMT_SPLIT = 1'b1
    } fmt_t;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] cb;
        logic [SAMPLE_W-1:0] y0;
        logic [SAMPLE_W-1:0] cr;
        logic [SAMPLE_W-1:0] y1;
    } pair_grp_t;

    // Slot advance per capture: one sample or one chroma/luma pair.
    function automatic slot_t slot_step(input fmt_t f);
        return (f == FMT_SPLIT) ? slot_t'(2) : slot_t'(1);
    endfunction

    // A capture in this slot completes the group.
    function automatic logic slot_last(input fmt_t f, input slot_t s);
        return (f == FMT_SPLIT) ? (s == slot_t'(2)) : (s == slot_t'(3));
    endfunction

endpackage

// File: rtl/ycc_phase_ctl.sv
module ycc_phase_ctl
    import ycc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fmt_t  fmt,
    input  logic  flush,
    input  logic  line_start,
    output logic  cap_en,
    output slot_t cap_slot,
    output logic  cap_last
);

    slot_t slot_q;
    logic  skip_q;

    always_comb begin
        cap_en   = !flush && (line_start || !skip_q || (fmt == FMT_BYTE));
        cap_slot = line_start ? slot_t'(0) : slot_q;
        cap_last = slot_last(fmt, cap_slot);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            slot_q <= '0;
            skip_q <= 1'b0;
        end else if (cap_en) begin
            slot_q <= cap_last ? slot_t'(0) : slot_t'(cap_slot + slot_step(fmt));
            skip_q <= (fmt == FMT_SPLIT);
        end else begin
            skip_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ycc_group_asm.sv
module ycc_group_asm
    import ycc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  fmt_t                fmt,
    input  logic                cap_en,
    input  slot_t               cap_slot,
    input  logic                cap_last,
    input  logic [BUS_W-1:0]    din,
    output pair_grp_t           grp_o,
    output logic                valid_o
);

    pair_grp_t part_q;
    pair_grp_t merged;
    pair_grp_t grp_q;
    logic      valid_q;

    logic [SAMPLE_W-1:0] lo_byte;
    logic [SAMPLE_W-1:0] hi_byte;

    assign lo_byte = din[SAMPLE_W-1:0];
    assign hi_byte = din[BUS_W-1:SAMPLE_W];

    always_comb begin
        merged = part_q;
        if (fmt == FMT_SPLIT) begin
            if (cap_slot == slot_t'(0)) begin
                merged.cb = hi_byte;
                merged.y0 = lo_byte;
            end else begin
                merged.cr = hi_byte;
                merged.y1 = lo_byte;
            end
        end else begin
            case (cap_slot)
                slot_t'(0): merged.cb = lo_byte;
                slot_t'(1): merged.y0 = lo_byte;
                slot_t'(2): merged.cr = lo_byte;
                default:    merged.y1 = lo_byte;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q  <= '0;
            grp_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= cap_en && cap_last;
            if (cap_en) begin
                part_q <= merged;
                if (cap_last) begin
                    grp_q <= merged;
                end
            end
        end
    end

    assign grp_o   = grp_q;
    assign valid_o = valid_q;

endmodule

// File: rtl/ycc_pair_demux.sv
module ycc_pair_demux
    import ycc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_sel,
    input  logic                line_start,
    input  logic [BUS_W-1:0]    din,
    output logic [SAMPLE_W-1:0] cb_o,
    output logic [SAMPLE_W-1:0] y0_o,
    output logic [SAMPLE_W-1:0] cr_o,
    output logic [SAMPLE_W-1:0] y1_o,
    output logic                valid_o
);

    fmt_t      mode_q;
    logic      flush;
    logic      cap_en;
    slot_t     cap_slot;
    logic      cap_last;
    pair_grp_t grp;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= FMT_BYTE;
        end else begin
            mode_q <= fmt_t'(mode_sel);
        end
    end

    assign flush = (fmt_t'(mode_sel) != mode_q);

    ycc_phase_ctl u_phase (
        .clk        (clk),
        .rst        (rst),
        .fmt        (mode_q),
        .flush      (flush),
        .line_start (line_start),
        .cap_en     (cap_en),
        .cap_slot   (cap_slot),
        .cap_last   (cap_last)
    );

    ycc_group_asm u_asm (
        .clk      (clk),
        .rst      (rst),
        .fmt      (mode_q),
        .cap_en   (cap_en),
        .cap_slot (cap_slot),
        .cap_last (cap_last),
        .din      (din),
        .grp_o    (grp),
        .valid_o  (valid_o)
    );

    assign cb_o = grp.cb;
    assign y0_o = grp.y0;
    assign cr_o = grp.cr;
    assign y1_o = grp.y1;

endmodule

// File: rtl/ycc_pair_demux_chk.sv
module ycc_pair_demux_chk
    import ycc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                mode_sel,
    input logic                mode_q,
    input logic [BUS_W-1:0]    din,
    input logic [SAMPLE_W-1:0] cr_o,
    input logic [SAMPLE_W-1:0] y1_o,
    input logic                valid_o
);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !valid_o); // R1

    AST_BYTE_LAST_LUMA: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !mode_q) |-> (y1_o == $past(din[SAMPLE_W-1:0]))); // R2

    AST_SPLIT_LAST_PAIR: assert property (@(posedge clk) disable iff (rst)
        (valid_o && mode_q) |-> (cr_o == $past(din[BUS_W-1:SAMPLE_W]) &&
                                 y1_o == $past(din[SAMPLE_W-1:0]))); // R3

    AST_SPLIT_NO_BACK2BACK: assert property (@(posedge clk) disable iff (rst)
        (valid_o && mode_q && mode_sel) |=> !valid_o); // R4

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R5

    AST_FLUSH_NO_EMIT: assert property (@(posedge clk) disable iff (rst)
        (mode_sel != mode_q) |=> !valid_o); // R7

endmodule

bind ycc_pair_demux ycc_pair_demux_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .mode_q   (mode_q),
    .din      (din),
    .cr_o     (cr_o),
    .y1_o     (y1_o),
    .valid_o  (valid_o)
);

// File: tb/ycc_pair_demux_tb.sv
module ycc_pair_demux_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 6;

    // Each entry is {cb, y0, cr, y1}.
    localparam logic [31:0] VEC [NVEC] = '{
        32'h11_22_33_44,
        32'hA0_B1_C2_D3,
        32'h00_FF_80_7F,
        32'h5A_A5_3C_C3,
        32'h01_02_04_08,
        32'hFE_10_EF_20
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_sel = 1'b0;
    logic        line_start = 1'b0;
    logic [15:0] din = '0;
    logic [7:0]  cb_o, y0_o, cr_o, y1_o;
    logic        valid_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ycc_pair_demux u_dut (
        .clk        (clk),
        .rst        (rst),
        .mode_sel   (mode_sel),
        .line_start (line_start),
        .din        (din),
        .cb_o       (cb_o),
        .y0_o       (y0_o),
        .cr_o       (cr_o),
        .y1_o       (y1_o),
        .valid_o    (valid_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    // Apply inputs just after an edge, then advance past the next edge.
    task automatic step(input logic ls, input logic [15:0] d);
        line_start = ls;
        din = d;
        @(posedge clk);
        #1;
        line_start = 1'b0;
    endtask

    function automatic logic [31:0] grp();
        return {cb_o, y0_o, cr_o, y1_o};
    endfunction

    task automatic send_byte_grp(input logic ls, input logic [31:0] g, input logic [7:0] hi);
        step(ls,   {hi, g[31:24]});
        step(1'b0, {hi, g[23:16]});
        step(1'b0, {hi, g[15:8]});
        step(1'b0, {hi, g[7:0]});
    endtask

    task automatic send_split_grp(input logic ls, input logic [31:0] g);
        step(ls,   {g[31:24], g[23:16]});
        step(1'b0, 16'hEEEE);
        check("R4 no strobe on skipped edge", {31'd0, valid_o}, 32'd0);
        step(1'b0, {g[15:8], g[7:0]});
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                bad++;
                total++;
                $display("FAIL watchdog expired got=%0d exp<=%0d", cycles, WATCHDOG);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        @(posedge clk); #1;
        step(1'b0, 16'h1234);
        step(1'b0, 16'h5678);
        check("R1 valid in reset", {31'd0, valid_o}, 32'd0);
        rst = 1'b0;
        step(1'b0, 16'h0000);
        check("R1 valid after reset", {31'd0, valid_o}, 32'd0);
        check("R1 outputs after reset", grp(), 32'd0);

        // Table walk, byte-serial format (R2, R5, R8)
        for (int i = 0; i < NVEC; i++) begin
            send_byte_grp(i == 0, VEC[i], 8'h99);
            check("R5 strobe after last byte sample", {31'd0, valid_o}, 32'd1);
            check("R2 byte group order", grp(), VEC[i]);
        end

        // Hold after strobe (R5)
        step(1'b0, 16'h0077);
        check("R5 strobe single cycle", {31'd0, valid_o}, 32'd0);
        check("R5 outputs held", grp(), VEC[NVEC-1]);
        step(1'b0, 16'h0066);

        // Upper byte ignored in byte format (R8)
        send_byte_grp(1'b1, VEC[0], 8'h00);
        check("R8 high byte zero", grp(), VEC[0]);
        send_byte_grp(1'b1, VEC[0], 8'hFF);
        check("R8 high byte ones", grp(), VEC[0]);

        // Line start mid-group (R6)
        step(1'b0, 16'h00AA);
        step(1'b0, 16'h00BB);
        send_byte_grp(1'b1, VEC[3], 8'h42);
        check("R6 byte realign", grp(), VEC[3]);

        // Switch to split-bus; the switching edge is a flush
        mode_sel = 1'b1;
        step(1'b0, 16'hDDDD);
        check("R7 no strobe on format change", {31'd0, valid_o}, 32'd0);
        for (int i = 0; i < NVEC; i++) begin
            send_split_grp(i == 0, VEC[i]);
            check("R5 strobe after last pair", {31'd0, valid_o}, 32'd1);
            check("R3 split group order", grp(), VEC[i]);
            step(1'b0, 16'hEEEE);
        end

        // Line start on what would be a skip edge (R6)
        step(1'b0, {VEC[2][31:24], VEC[2][23:16]});
        send_split_grp(1'b1, VEC[4]);
        check("R6 split realign", grp(), VEC[4]);

        // Mode change mid-group discards partial (R7)
        mode_sel = 1'b0;
        step(1'b0, 16'h0000);
        step(1'b0, 16'h0031);
        step(1'b0, 16'h0032);
        step(1'b0, 16'h0033);
        mode_sel = 1'b1;
        step(1'b0, 16'h3434);
        check("R7 flush edge no strobe", {31'd0, valid_o}, 32'd0);
        send_split_grp(1'b0, VEC[5]);
        check("R7 new format group clean", grp(), VEC[5]);

        // Back to byte after half a split group
        step(1'b0, 16'h0000);
        step(1'b0, {VEC[1][31:24], VEC[1][23:16]});
        mode_sel = 1'b0;
        step(1'b0, 16'h0000);
        send_byte_grp(1'b0, VEC[2], 8'h55);
        check("R7 byte after split partial", grp(), VEC[2]);

        // Reset mid-group returns to byte format (R1)
        mode_sel = 1'b1;
        step(1'b0, 16'h0000);
        step(1'b0, 16'h1111);
        mode_sel = 1'b0;
        rst = 1'b1;
        step(1'b0, 16'h0000);
        rst = 1'b0;
        check("R1 reset clears outputs", grp(), 32'd0);
        send_byte_grp(1'b0, VEC[1], 8'h00);
        check("R1 byte default after reset", grp(), VEC[1]);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule